// File: doc/BRIEF.md
# External Multiplexed Bus Cycle Controller

This block carries out one external memory or peripheral access at a time for a small processor core. The core presents a 24-bit byte address, write data, two byte enables and a direction flag. The block answers with a one-cycle done pulse and the read data, or with a one-cycle error pulse if the request cannot be served. On the pin side it drives a 16-bit shared address/data port with per-byte output enables, a separate 16-bit address port, an 8-bit upper-address port, an address latch enable, a read strobe and three write strobes.

A 2-bit bus-type input picks the data width (8 or 16 bits) and how addresses are presented. In the multiplexed modes the offset goes out on the shared port during an ALE phase, where an external latch captures it, before the port carries data. In the separate-address modes the offset goes out on the dedicated address port. With segmentation on, address bits 23..16 are driven constantly on the upper-address port. With segmentation off, only the first 64 KB segment can be reached. A programmable wait-state count stretches the command strobe. On an 8-bit bus, a word request becomes two byte cycles.

Top module: `ext_bus_sequencer`

## Requirements
- R1: `cfg_bus_type` selects the bus mode. Bit 1 gives the data width (0 = 8-bit, 1 = 16-bit) and bit 0 the address mode (0 = separate address port, 1 = multiplexed on the shared port), giving 00, 01, 10 and 11. The configuration is captured when a request is accepted.
- R2: A request is rejected, with `rsp_err` high in the same cycle as `req_valid` and `req_ready`, and causes no bus activity, in any of these cases: `cfg_bus_en` is low, `req_be` is 00, or segmentation is off while address bits 23..16 are not all zero.
- R3: With segmentation on, `upa_oe` is 1 and `upa_out` carries address bits 23..16 of the current or last access. With segmentation off, `upa_oe` is 0 and `upa_out` is 0.
- R4: A multiplexed access runs through these cycles in order. First, one cycle with `ale` high and the offset on the shared port. Next, one cycle with `ale` low and the offset still driven. Next, one setup cycle with the offset removed. Only after that is a strobe asserted.
- R5: In 8-bit multiplexed mode, `ad_out[15:8]` holds address bits 15..8, enabled, for the whole access, and only the low byte switches between address and data. In 16-bit multiplexed mode, the whole port switches between address and data, and address bit 0 is output as 0.
- R6: In the separate-address modes, `addr_out` carries the 16-bit offset, `ale` stays low, and data uses the shared port: the low byte only for 8-bit, all 16 bits for 16-bit. In the multiplexed modes, `addr_out` is 0.
- R7: Reads assert `rd_n`. In 8-bit mode, writes assert `wr_n`. In 16-bit mode, writes assert `wrl_n` if `req_be[0]` is set and `wrh_n` if `req_be[1]` is set, with `wr_n` high. At most one of reading and writing is active at a time.
- R8: Each strobe lasts 1 + `cfg_waits` cycles (0..15). Read data is sampled from `ad_in` on the last strobe cycle. Byte lanes not enabled return 0.
- R9: All data lanes of the shared port are released in the cycle before `rd_n` falls and stay released while `rd_n` is low. The cycle after any strobe ends has no strobe and no ALE.
- R10: Counting the acceptance edge as cycle 0, `rsp_done` is high in cycle P*(5+W) for multiplexed modes and P*(3+W) for separate modes, where W is the wait count and P is the number of byte cycles.
- R11: On an 8-bit bus, `req_be`=11 runs two byte cycles: the low byte at address bit 0 = 0, then the high byte at address bit 0 = 1. `req_be`=01 runs one cycle on the low byte at bit 0 = 0, and `req_be`=10 runs one cycle on the high byte at bit 0 = 1. On a 16-bit bus, P = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bus_en | input | 1 | External bus enable |
| cfg_bus_type | input | 2 | Width / address-mode select |
| cfg_seg_en | input | 1 | Segmentation enable |
| cfg_waits | input | WAIT_W | Wait-state count |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables |
| req_ready | output | 1 | Idle; request taken this cycle |
| rsp_done | output | 1 | Access complete pulse |
| rsp_err | output | 1 | Request rejected pulse |
| rsp_rdata | output | 16 | Read data |
| ad_out | output | 16 | Shared port output value |
| ad_oe_lo | output | 1 | Shared port low-byte enable |
| ad_oe_hi | output | 1 | Shared port high-byte enable |
| ad_in | input | 16 | Shared port input value |
| addr_out | output | 16 | Separate address port |
| upa_out | output | 8 | Upper address lines |
| upa_oe | output | 1 | Upper address enable |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | 8-bit write strobe, active low |
| wrl_n | output | 1 | Low-byte write strobe, active low |
| wrh_n | output | 1 | High-byte write strobe, active low |

## Verification
The checker watches every cycle for several conditions:
- no strobe during ALE, and a one-cycle ALE;
- no strobe directly after ALE;
- the shared data lanes released before and during a read strobe;
- an idle cycle after every strobe;
- the held upper byte in 8-bit multiplexed mode;
- read/write exclusion;
- quiet upper lines when segmentation is off;
- no bus activity after a rejected request.

Only the bench scenarios can show the rest, using a model device with an address latch:
- that the latched address, upper segment and lane selection are right;
- that write data arrives with the right strobes;
- strobe width and read sampling on exactly the last strobe cycle;
- the two-cycle byte split and the total done latency.

// File: rtl/ext_bus_sequencer.sv
module ext_bus_sequencer #(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_bus_en,
  input  logic [1:0]        cfg_bus_type,
  input  logic              cfg_seg_en,
  input  logic [WAIT_W-1:0] cfg_waits,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [23:0]       req_addr,
  input  logic [15:0]       req_wdata,
  input  logic [1:0]        req_be,
  output logic              req_ready,
  output logic              rsp_done,
  output logic              rsp_err,
  output logic [15:0]       rsp_rdata,
  output logic [15:0]       ad_out,
  output logic              ad_oe_lo,
  output logic              ad_oe_hi,
  input  logic [15:0]       ad_in,
  output logic [15:0]       addr_out,
  output logic [7:0]        upa_out,
  output logic              upa_oe,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              wrl_n,
  output logic              wrh_n
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ALE, ST_LATCH, ST_SETUP, ST_CMD, ST_TURN
  } state_t;

  state_t            st;
  logic              wide_q, mux_q, seg_q, wr_q, phase_q;
  logic [WAIT_W-1:0] waits_q, wcnt;
  logic [23:1]       addr_q;
  logic [15:0]       wdata_q, rdata_q;
  logic [1:0]        be_q;

  logic        bad, accept, two_q, lane, last_piece, addr_ph, data_ph, strobe_ph;
  logic [15:0] off;
  logic [7:0]  bdata;

  assign bad    = !cfg_bus_en || (req_be == 2'b00) ||
                  (!cfg_seg_en && (req_addr[23:16] != 8'h00));
  assign accept = (st == ST_IDLE) && req_valid && !bad;

  assign req_ready = (st == ST_IDLE);
  assign rsp_err   = (st == ST_IDLE) && req_valid && bad;

  assign two_q      = !wide_q && (be_q == 2'b11);
  assign lane       = wide_q ? 1'b0 : ((be_q == 2'b10) ? 1'b1 : phase_q);
  assign last_piece = !two_q || phase_q;
  assign rsp_done   = (st == ST_TURN) && last_piece;
  assign rsp_rdata  = rdata_q;

  assign off   = {addr_q[15:1], lane};
  assign bdata = lane ? wdata_q[15:8] : wdata_q[7:0];

  assign addr_ph   = mux_q && (st == ST_ALE || st == ST_LATCH);
  assign data_ph   = (st == ST_SETUP) || (st == ST_CMD) || (st == ST_TURN);
  assign strobe_ph = (st == ST_CMD);

  always_comb begin
    ad_out = 16'h0000;
    if (addr_ph)
      ad_out = off;
    else if (data_ph)
      ad_out = wide_q ? wdata_q : {(mux_q ? off[15:8] : 8'h00), bdata};
  end

  assign ad_oe_lo = addr_ph || (data_ph && wr_q);
  assign ad_oe_hi = addr_ph || (data_ph && (wide_q ? wr_q : mux_q));

  assign addr_out = mux_q ? 16'h0000 : off;
  assign upa_out  = seg_q ? addr_q[23:16] : 8'h00;
  assign upa_oe   = seg_q;

  assign ale   = (st == ST_ALE);
  assign rd_n  = !(strobe_ph && !wr_q);
  assign wr_n  = !(strobe_ph && wr_q && !wide_q);
  assign wrl_n = !(strobe_ph && wr_q && wide_q && be_q[0]);
  assign wrh_n = !(strobe_ph && wr_q && wide_q && be_q[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      wide_q  <= 1'b0;
      mux_q   <= 1'b0;
      seg_q   <= 1'b0;
      wr_q    <= 1'b0;
      phase_q <= 1'b0;
      waits_q <= '0;
      wcnt    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      be_q    <= '0;
    end else begin
      case (st)
        ST_IDLE: if (accept) begin
          wide_q  <= cfg_bus_type[1];
          mux_q   <= cfg_bus_type[0];
          seg_q   <= cfg_seg_en;
          waits_q <= cfg_waits;
          wr_q    <= req_write;
          addr_q  <= req_addr[23:1];
          wdata_q <= req_wdata;
          be_q    <= req_be;
          phase_q <= 1'b0;
          rdata_q <= '0;
          st      <= cfg_bus_type[0] ? ST_ALE : ST_SETUP;
        end
        ST_ALE:   st <= ST_LATCH;
        ST_LATCH: st <= ST_SETUP;
        ST_SETUP: begin
          wcnt <= waits_q;
          st   <= ST_CMD;
        end
        ST_CMD: begin
          if (wcnt == '0) begin
            st <= ST_TURN;
            if (!wr_q) begin
              if (wide_q)
                rdata_q <= ad_in & {{8{be_q[1]}}, {8{be_q[0]}}};
              else if (lane)
                rdata_q[15:8] <= ad_in[7:0];
              else
                rdata_q[7:0] <= ad_in[7:0];
            end
          end else begin
            wcnt <= wcnt - 1'b1;
          end
        end
        ST_TURN: begin
          if (last_piece) begin
            st <= ST_IDLE;
          end else begin
            phase_q <= 1'b1;
            st      <= mux_q ? ST_ALE : ST_SETUP;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ext_bus_sequencer_chk.sv
module ext_bus_sequencer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ale,
  input logic        rd_n,
  input logic        wr_n,
  input logic        wrl_n,
  input logic        wrh_n,
  input logic        ad_oe_lo,
  input logic        ad_oe_hi,
  input logic [15:0] ad_out,
  input logic        upa_oe,
  input logic [7:0]  upa_out,
  input logic        rsp_done,
  input logic        rsp_err,
  input logic        mux_q,
  input logic        wide_q
);

  logic any_strobe;
  assign any_strobe = !(rd_n && wr_n && wrl_n && wrh_n);

  a_r4_no_strobe_in_ale: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> !any_strobe);

  a_r4_ale_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  a_r4_gap_after_ale: assert property (@(posedge clk) disable iff (!rst_n)
    (any_strobe && !$past(any_strobe)) |-> !$past(ale));

  a_r5_hi_byte_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mux_q && !wide_q && ad_oe_hi && $past(ad_oe_hi)) |-> $stable(ad_out[15:8]));

  a_r9_lanes_off_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> (!ad_oe_lo && (!ad_oe_hi || (mux_q && !wide_q))));

  a_r9_released_before_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && $past(rd_n)) |-> !$past(ad_oe_lo));

  a_r9_idle_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(any_strobe) |-> (!ale && !any_strobe));

  a_r7_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> (wr_n && wrl_n && wrh_n));

  a_r3_upper_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !upa_oe |-> (upa_out == 8'h00));

  a_r2_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |=> (!ale && !any_strobe && !rsp_done));

endmodule

bind ext_bus_sequencer ext_bus_sequencer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
  .wrl_n(wrl_n), .wrh_n(wrh_n), .ad_oe_lo(ad_oe_lo), .ad_oe_hi(ad_oe_hi),
  .ad_out(ad_out), .upa_oe(upa_oe), .upa_out(upa_out),
  .rsp_done(rsp_done), .rsp_err(rsp_err), .mux_q(mux_q), .wide_q(wide_q)
);

// File: tb/ext_bus_sequencer_tb.sv
module ext_bus_sequencer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic cfg_bus_en = 0, cfg_seg_en = 0;
  logic [1:0] cfg_bus_type = 0;
  logic [3:0] cfg_waits = 0;
  logic req_valid = 0, req_write = 0;
  logic [23:0] req_addr = 0;
  logic [15:0] req_wdata = 0;
  logic [1:0] req_be = 0;
  logic req_ready, rsp_done, rsp_err;
  logic [15:0] rsp_rdata, ad_out, ad_in, addr_out;
  logic ad_oe_lo, ad_oe_hi, upa_oe, ale, rd_n, wr_n, wrl_n, wrh_n;
  logic [7:0] upa_out;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_bus_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_bus_en(cfg_bus_en), .cfg_bus_type(cfg_bus_type),
    .cfg_seg_en(cfg_seg_en), .cfg_waits(cfg_waits), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .req_ready(req_ready), .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .ad_out(ad_out), .ad_oe_lo(ad_oe_lo), .ad_oe_hi(ad_oe_hi), .ad_in(ad_in),
    .addr_out(addr_out), .upa_out(upa_out), .upa_oe(upa_oe), .ale(ale),
    .rd_n(rd_n), .wr_n(wr_n), .wrl_n(wrl_n), .wrh_n(wrh_n));

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] devb(input logic [23:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ 8'h5A;
  endfunction

  // model device: external address latch plus read data
  logic [15:0] lat;
  logic [3:0]  rd_cnt;
  logic [23:0] full;
  logic [15:0] ext_off, dev_data;
  always @(negedge ale) lat <= ad_out;
  always @(posedge clk) rd_cnt <= rd_n ? 4'd0 : rd_cnt + 4'd1;

  assign ext_off  = cfg_bus_type[0] ? {(cfg_bus_type[1] ? lat[15:8] : ad_out[15:8]), lat[7:0]} : addr_out;
  assign full     = {(upa_oe ? upa_out : 8'h00), ext_off};
  assign dev_data = cfg_bus_type[1] ? {devb({full[23:1], 1'b1}), devb({full[23:1], 1'b0})}
                                    : {8'hEE, devb(full)};
  assign ad_in    = (rd_cnt == cfg_waits) ? dev_data : 16'hDEAD;

  // strobe event monitor
  logic [23:0] ev_addr [4];
  logic [15:0] ev_data [4];
  logic [3:0]  ev_str  [4];
  int          ev_w    [4];
  int n_ev = 0, cur_w = 0;
  bit act = 0;
  logic [23:0] c_addr; logic [15:0] c_data; logic [3:0] c_str;

  always @(negedge clk) begin
    logic [3:0] s;
    s = {~rd_n, ~wr_n, ~wrl_n, ~wrh_n};
    if (s != 0) begin
      if (!act) begin act = 1; cur_w = 0; end
      cur_w++;
      c_str = s; c_addr = full; c_data = ad_out;
    end else if (act) begin
      act = 0;
      if (n_ev < 4) begin
        ev_addr[n_ev] = c_addr; ev_data[n_ev] = c_data;
        ev_str[n_ev] = c_str;   ev_w[n_ev] = cur_w;
      end
      n_ev++;
    end
  end

  task automatic txn(input logic en, input logic [1:0] bt, input logic seg, input logic [3:0] w,
                     input logic wr, input logic [23:0] a, input logic [15:0] d, input logic [1:0] be);
    bit bad, wide, mux;
    int np, cyc, expl;
    logic ln [2];
    logic [15:0] erd, got;
    bad  = !en || be == 0 || (!seg && a[23:16] != 0);
    wide = bt[1]; mux = bt[0];
    @(negedge clk);
    cfg_bus_en = en; cfg_bus_type = bt; cfg_seg_en = seg; cfg_waits = w;
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    n_ev = 0;
    #1;
    chk(rsp_err == bad, "R2 err flag", rsp_err, bad);
    chk(req_ready == 1, "R2 ready while idle", req_ready, 1);
    if (bad) begin
      @(negedge clk); req_valid = 0;
      repeat (4) @(negedge clk);
      chk(n_ev == 0, "R2 rejected access is quiet", n_ev, 0);
      return;
    end
    @(negedge clk); req_valid = 0;
    cyc = 1;
    while (!rsp_done && cyc < 100) begin @(negedge clk); cyc++; end
    got = rsp_rdata;
    if (wide) begin np = 1; ln[0] = 0; end
    else if (be == 2'b11) begin np = 2; ln[0] = 0; ln[1] = 1; end
    else begin np = 1; ln[0] = (be == 2'b10); end
    expl = np * ((mux ? 5 : 3) + w);
    chk(cyc == expl, "R10 done latency", cyc, expl);
    @(negedge clk);
    chk(n_ev == np, "R11 number of byte cycles", n_ev, np);
    erd = 0;
    for (int i = 0; i < np && i < n_ev; i++) begin
      logic [23:0] ea; logic [3:0] es;
      ea = {(seg ? a[23:16] : 8'h00), a[15:1], (wide ? 1'b0 : ln[i])};
      if (!wr) es = 4'b1000;
      else if (!wide) es = 4'b0100;
      else es = {2'b00, be[0], be[1]};
      chk(ev_addr[i] == ea, mux ? "R4 R5 latched address" : "R6 separate address", ev_addr[i], ea);
      chk(ev_str[i] == es, "R7 strobe select", ev_str[i], es);
      chk(ev_w[i] == w + 1, "R8 strobe width", ev_w[i], w + 1);
      if (wr) begin
        if (wide)
          chk(ev_data[i] == d, "R5 R6 word write data", ev_data[i], d);
        else
          chk(ev_data[i][7:0] == (ln[i] ? d[15:8] : d[7:0]), "R11 byte write data",
              ev_data[i][7:0], ln[i] ? d[15:8] : d[7:0]);
      end else if (!wide) begin
        if (ln[i]) erd[15:8] = devb(ea); else erd[7:0] = devb(ea);
      end
    end
    if (!wr) begin
      if (wide) erd = {devb({a[23:1] & (seg ? 23'h7FFFFF : 23'h007FFF), 1'b1}),
                       devb({a[23:1] & (seg ? 23'h7FFFFF : 23'h007FFF), 1'b0})}
                      & {{8{be[1]}}, {8{be[0]}}};
      chk(got == erd, "R8 read data", got, erd);
    end
    chk(upa_oe == seg, "R3 upper enable", upa_oe, seg);
    chk(upa_out == (seg ? a[23:16] : 8'h00), "R3 upper lines", upa_out, seg ? a[23:16] : 8'h00);
    if (mux) chk(addr_out == 0, "R6 address port idle in mux mode", addr_out, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !rsp_done && !rsp_err, "R2 reset idle", {req_ready, rsp_done, rsp_err}, 3'b100);
    chk(!ale && rd_n && wr_n && wrl_n && wrh_n, "R4 reset strobes", {ale, rd_n, wr_n, wrl_n, wrh_n}, 5'b01111);
    chk(!ad_oe_lo && !ad_oe_hi && !upa_oe, "R3 reset enables", {ad_oe_lo, ad_oe_hi, upa_oe}, 0);

    // directed corner cases
    txn(0, 2'b11, 1, 0, 1, 24'h12_3456, 16'hA5A5, 2'b11);   // R2 bus disabled
    txn(1, 2'b10, 0, 0, 0, 24'h01_0000, 16'h0, 2'b11);      // R2 R3 nonzero segment
    txn(1, 2'b01, 1, 0, 1, 24'h00_1000, 16'h1234, 2'b00);   // R2 no byte enabled
    txn(1, 2'b11, 1, 0, 0, 24'hAB_CDEF, 16'h0, 2'b11);      // R1 R4 mux16 read, no waits
    txn(1, 2'b11, 1, 15, 1, 24'h7F_FFFE, 16'hBEEF, 2'b10);  // R7 high-byte write, max waits
    txn(1, 2'b01, 1, 2, 1, 24'h3C_4421, 16'hC0DE, 2'b11);   // R11 mux8 word write
    txn(1, 2'b01, 0, 1, 0, 24'h00_9A00, 16'h0, 2'b11);      // R5 R11 mux8 word read
    txn(1, 2'b00, 1, 3, 0, 24'h55_0101, 16'h0, 2'b10);      // R6 demux8 high byte read
    txn(1, 2'b10, 1, 0, 1, 24'h22_8888, 16'h7E81, 2'b01);   // R6 R7 demux16 low write

    for (int k = 0; k < 200; k++) begin
      logic [1:0] bt, be; logic seg, wr, en; logic [3:0] w; logic [23:0] a;
      bt  = 2'($urandom_range(0, 3));
      seg = 1'($urandom_range(0, 1));
      w   = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(0, 15)) : 4'($urandom_range(0, 2));
      wr  = 1'($urandom_range(0, 1));
      en  = ($urandom_range(0, 15) != 0);
      be  = ($urandom_range(0, 15) == 0) ? 2'b00 : 2'($urandom_range(1, 3));
      a   = 24'($urandom);
      if (!seg && $urandom_range(0, 7) != 0) a[23:16] = 0;
      txn(en, bt, seg, w, wr, a, 16'($urandom), be);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule